// File: doc/BRIEF.md
# Quarter-Pel Motion Vector Refinement Engine

This block refines a half-pel motion vector of one 4x4 block to quarter-pel accuracy. It takes the chosen half-pel vector and tries the eight quarter-pel displacements that surround it. For each displacement it forms the sixteen quarter samples while it runs. Each quarter sample is the rounded mean of two neighbouring samples on a half-pel grid. Four absolute-difference engines add up a SAD for each displacement. At the end the block reports the displacement with the smallest SAD, together with that SAD.

Samples come from an external window store that holds integer and half pixels on one half-pel grid. The store is read through four byte-wide ports. The current block is read through two byte-wide ports. Both stores answer in the same cycle they are addressed. The engines work in two pairs. In each pair, one engine fetches the centre sample and the current pixel, and its partner uses the held copies one cycle later. A one-cycle start pulse launches a search. A one-cycle done pulse marks the result.

Top module: `qpel_refine`

## Requirements
- R1: The candidate offsets (dx, dy) cover every pair with both values in {-1, 0, 1} except (0, 0). Their index k runs in raster order, with dy as the major key: k0=(-1,-1), k1=(0,-1), k2=(1,-1), k3=(-1,0), k4=(1,0), k5=(-1,1), k6=(0,1), k7=(1,1). The reported vector is (2*hpX+dx, 2*hpY+dy) in quarter-pel units, as 4-bit two's complement. hpX and hpY are 2-bit two's complement values in -1..1.
- R2: A window sample at half-grid column c and row r sits at address r*16+c. Block pixel n (0..15) has column n%4 and row n/4. Its centre sample is at column 6+hpX+2*(n%4) and row 6+hpY+2*(n/4). Current pixel n is at current-store address n.
- R3: For offset k, the quarter sample of pixel n is (centre + neighbour + 1) >> 1. The neighbour is the sample at the centre column+dx and centre row+dy. The SAD is the sum of |quarter - current| over the 16 pixels.
- R4: In beat b (b = 0..63), which is the b-th cycle after the accepting edge counting from 0, both current-store addresses equal (b/2)%16. Each current pixel is therefore read once and reused in the next cycle.
- R5: The smallest SAD wins. When SADs are equal, the lower index k wins.
- R6: When start is accepted at edge E0, done is high only between edges E65 and E66. bestSad, bestMvX and bestMvY are valid while done is high.
- R7: A start pulse that arrives while a search is running has no effect. The result and its timing are those of the search already under way.
- R8: After reset, done, bestSad, bestMvX and bestMvY are all 0.
- R9: SADs do not wrap. A window of all 255 against a current block of all 0 gives a SAD of 4080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a search when idle |
| hpX | input | 2 | Half-pel vector, horizontal |
| hpY | input | 2 | Half-pel vector, vertical |
| swAddr0 | output | 8 | Window read address, port 0 |
| swAddr1 | output | 8 | Window read address, port 1 |
| swAddr2 | output | 8 | Window read address, port 2 |
| swAddr3 | output | 8 | Window read address, port 3 |
| swData0 | input | 8 | Window read data, port 0 |
| swData1 | input | 8 | Window read data, port 1 |
| swData2 | input | 8 | Window read data, port 2 |
| swData3 | input | 8 | Window read data, port 3 |
| cbAddr0 | output | 4 | Current-block address, port 0 |
| cbAddr1 | output | 4 | Current-block address, port 1 |
| cbData0 | input | 8 | Current-block data, port 0 |
| cbData1 | input | 8 | Current-block data, port 1 |
| done | output | 1 | One-cycle result strobe |
| bestMvX | output | 4 | Refined vector, horizontal, quarter-pel |
| bestMvY | output | 4 | Refined vector, vertical, quarter-pel |
| bestSad | output | 12 | SAD of the refined vector |

## Verification
The search runs on pseudo-random windows for all nine half-pel vectors. These runs show whether the addressing and the offset order follow each half-pel origin. A window in which one chosen offset matches the current block exactly shows whether the comparator picks the true minimum rather than a fixed index. A flat window in which all eight SADs tie exposes a wrong tie rule. A window of 255 against a current block of 0 exposes a truncated accumulator. A second start during a run, with a different vector on the inputs, shows whether the running search can be disturbed.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  localparam int BLK_DIM  = 4;
  localparam int BLK_PIX  = BLK_DIM * BLK_DIM;
  localparam int PIX_BITS = $clog2(BLK_PIX);
  localparam int NPOS     = 8;
  localparam int NPE      = 4;
  localparam int POS_BITS = $clog2(NPOS);

  typedef struct packed {
    logic                clr;
    logic                run;
    logic                fin;
    logic                pass;
    logic [PIX_BITS-1:0] pix;
    logic                phase;
  } ctrlT;

  // raster order over the 3x3 neighbourhood, centre skipped
  function automatic int posDx(input int k);
    int s;
    s = (k < NPOS / 2) ? k : k + 1;
    return (s % 3) - 1;
  endfunction

  function automatic int posDy(input int k);
    int s;
    s = (k < NPOS / 2) ? k : k + 1;
    return (s / 3) - 1;
  endfunction
endpackage

// File: rtl/qpel_absdiff_pe.sv
module qpel_absdiff_pe #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] sampA,
  input  logic [PIX_W-1:0] sampB,
  input  logic [PIX_W-1:0] curPix,
  output logic [PIX_W-1:0] absDiff
);
  logic [PIX_W:0]   sum;
  logic [PIX_W-1:0] qPix;

  always_comb begin
    sum     = {1'b0, sampA} + {1'b0, sampB} + {{PIX_W{1'b0}}, 1'b1};
    qPix    = sum[PIX_W:1];
    absDiff = (qPix >= curPix) ? (qPix - curPix) : (curPix - qPix);
  end
endmodule

// File: rtl/qpel_refine_ctrl.sv
module qpel_refine_ctrl
  import qpel_pkg::*;
#(
  parameter int CNT_W = PIX_BITS + 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctrlT ctl
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} stateT;

  localparam logic [CNT_W-1:0] LAST_BEAT = '1;

  stateT            state;
  logic [CNT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          beat  <= '0;
        end
        S_RUN: begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clr   = (state == S_IDLE) && start;
    ctl.run   = (state == S_RUN);
    ctl.fin   = (state == S_FIN);
    ctl.phase = beat[0];
    ctl.pix   = beat[PIX_BITS:1];
    ctl.pass  = beat[CNT_W-1];
  end

  // R7: a running search advances one beat per cycle whatever start does
  a_r7_run_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) && (beat != LAST_BEAT) |=> (state == S_RUN) && (beat == $past(beat) + 1'b1));
endmodule

// File: rtl/qpel_refine_dp.sv
module qpel_refine_dp
  import qpel_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int SW_COLS = 16,
  parameter int SW_AW   = 8,
  parameter int ORG     = 6,
  parameter int SAD_W   = 12,
  parameter int MV_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlT             ctl,
  input  logic [1:0]       hpX,
  input  logic [1:0]       hpY,
  output logic [SW_AW-1:0] swAddr [NPE],
  input  logic [PIX_W-1:0] swData [NPE],
  output logic [PIX_BITS-1:0] cbAddr [NPE/2],
  input  logic [PIX_W-1:0] cbData [NPE/2],
  output logic             done,
  output logic [MV_W-1:0]  bestMvX,
  output logic [MV_W-1:0]  bestMvY,
  output logic [SAD_W-1:0] bestSad
);
  localparam int NPAIR = NPE / 2;

  logic [1:0]       hpXq, hpYq;
  logic [PIX_W-1:0] centreReg [NPAIR];
  logic [PIX_W-1:0] curReg    [NPAIR];
  logic [PIX_W-1:0] peA [NPE], peB [NPE], peC [NPE], peOut [NPE];
  logic [SAD_W-1:0] sad [NPOS];
  logic [SAD_W-1:0] minSad;
  logic [POS_BITS-1:0] minIdx;

  function automatic logic [SW_AW-1:0] sampleAddr(input int hx, input int hy,
                                                  input int n, input int dx, input int dy);
    int col, row;
    col = ORG + hx + 2 * (n % BLK_DIM) + dx;
    row = ORG + hy + 2 * (n / BLK_DIM) + dy;
    return SW_AW'(row * SW_COLS + col);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hpXq <= '0;
      hpYq <= '0;
    end else if (ctl.clr) begin
      hpXq <= hpX;
      hpYq <= hpY;
    end
  end

  // address generation: even phase feeds the leading engine of each pair,
  // odd phase feeds its partner, which reuses the held centre and current pixel
  always_comb begin
    int hx, hy, n, posE, posO;
    hx = int'($signed(hpXq));
    hy = int'($signed(hpYq));
    n  = int'(ctl.pix);
    for (int g = 0; g < NPAIR; g++) begin
      posE = 2 * g + NPE * int'(ctl.pass);
      posO = posE + 1;
      if (!ctl.phase) begin
        swAddr[2*g]   = sampleAddr(hx, hy, n, 0, 0);
        swAddr[2*g+1] = sampleAddr(hx, hy, n, posDx(posE), posDy(posE));
      end else begin
        swAddr[2*g]   = sampleAddr(hx, hy, n, posDx(posO), posDy(posO));
        swAddr[2*g+1] = sampleAddr(hx, hy, n, 0, 0);
      end
      cbAddr[g] = ctl.pix;
      peA[2*g]   = swData[2*g];
      peB[2*g]   = swData[2*g+1];
      peC[2*g]   = cbData[g];
      peA[2*g+1] = centreReg[g];
      peB[2*g+1] = swData[2*g];
      peC[2*g+1] = curReg[g];
    end
  end

  for (genvar j = 0; j < NPE; j++) begin : g_pe
    qpel_absdiff_pe #(.PIX_W(PIX_W)) pe_i (
      .sampA  (peA[j]),
      .sampB  (peB[j]),
      .curPix (peC[j]),
      .absDiff(peOut[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NPAIR; g++) begin
        centreReg[g] <= '0;
        curReg[g]    <= '0;
      end
    end else if (ctl.run && !ctl.phase) begin
      for (int g = 0; g < NPAIR; g++) begin
        centreReg[g] <= swData[2*g];
        curReg[g]    <= cbData[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clr) begin
      for (int k = 0; k < NPOS; k++) sad[k] <= '0;
    end else if (ctl.run) begin
      for (int j = 0; j < NPE; j++) begin
        if (ctl.phase == j[0])
          sad[j + NPE * int'(ctl.pass)] <= sad[j + NPE * int'(ctl.pass)]
                                         + SAD_W'(peOut[j]);
      end
    end
  end

  always_comb begin
    minSad = sad[0];
    minIdx = '0;
    for (int k = 1; k < NPOS; k++) begin
      if (sad[k] < minSad) begin
        minSad = sad[k];
        minIdx = POS_BITS'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      bestSad <= '0;
      bestMvX <= '0;
      bestMvY <= '0;
    end else begin
      done <= ctl.fin;
      if (ctl.fin) begin
        bestSad <= minSad;
        bestMvX <= MV_W'(2 * int'($signed(hpXq)) + posDx(int'(minIdx)));
        bestMvY <= MV_W'(2 * int'($signed(hpYq)) + posDy(int'(minIdx)));
      end
    end
  end

  // R2: both pairs fetch the same centre sample in the leading phase
  a_r2_centre_shared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run && !ctl.phase |-> swAddr[0] == swAddr[2]);
  // R4: the partner phase keeps the current pixel fetched one cycle earlier
  a_r4_cur_reuse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run && ctl.phase |-> (cbAddr[0] == $past(cbAddr[0])) && (cbAddr[1] == $past(cbAddr[1])));
  // R7: the latched half-pel vector cannot move during a search
  a_r7_hp_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> $stable(hpXq) && $stable(hpYq));
  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R1: reported vector stays inside the reachable quarter-pel range
  a_r1_mv_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($signed(bestMvX) >= -3) && ($signed(bestMvX) <= 3)
          && ($signed(bestMvY) >= -3) && ($signed(bestMvY) <= 3));
endmodule

// File: rtl/qpel_refine.sv
module qpel_refine
  import qpel_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int SW_COLS = 16,
  parameter int SW_AW   = 8,
  parameter int ORG     = 6,
  parameter int SAD_W   = 12,
  parameter int MV_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       hpX,
  input  logic [1:0]       hpY,
  output logic [SW_AW-1:0] swAddr0,
  output logic [SW_AW-1:0] swAddr1,
  output logic [SW_AW-1:0] swAddr2,
  output logic [SW_AW-1:0] swAddr3,
  input  logic [PIX_W-1:0] swData0,
  input  logic [PIX_W-1:0] swData1,
  input  logic [PIX_W-1:0] swData2,
  input  logic [PIX_W-1:0] swData3,
  output logic [PIX_BITS-1:0] cbAddr0,
  output logic [PIX_BITS-1:0] cbAddr1,
  input  logic [PIX_W-1:0] cbData0,
  input  logic [PIX_W-1:0] cbData1,
  output logic             done,
  output logic [MV_W-1:0]  bestMvX,
  output logic [MV_W-1:0]  bestMvY,
  output logic [SAD_W-1:0] bestSad
);
  ctrlT                ctl;
  logic [SW_AW-1:0]    swAddrArr [NPE];
  logic [PIX_W-1:0]    swDataArr [NPE];
  logic [PIX_BITS-1:0] cbAddrArr [NPE/2];
  logic [PIX_W-1:0]    cbDataArr [NPE/2];

  always_comb begin
    swDataArr[0] = swData0;
    swDataArr[1] = swData1;
    swDataArr[2] = swData2;
    swDataArr[3] = swData3;
    cbDataArr[0] = cbData0;
    cbDataArr[1] = cbData1;
    swAddr0 = swAddrArr[0];
    swAddr1 = swAddrArr[1];
    swAddr2 = swAddrArr[2];
    swAddr3 = swAddrArr[3];
    cbAddr0 = cbAddrArr[0];
    cbAddr1 = cbAddrArr[1];
  end

  qpel_refine_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl)
  );

  qpel_refine_dp #(
    .PIX_W(PIX_W), .SW_COLS(SW_COLS), .SW_AW(SW_AW),
    .ORG(ORG), .SAD_W(SAD_W), .MV_W(MV_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .hpX    (hpX),
    .hpY    (hpY),
    .swAddr (swAddrArr),
    .swData (swDataArr),
    .cbAddr (cbAddrArr),
    .cbData (cbDataArr),
    .done   (done),
    .bestMvX(bestMvX),
    .bestMvY(bestMvY),
    .bestSad(bestSad)
  );
endmodule

// File: tb/qpel_refine_tb_top.sv
module qpel_refine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] hpX = '0, hpY = '0;
  logic [7:0] swAddr0, swAddr1, swAddr2, swAddr3;
  logic [7:0] swData0, swData1, swData2, swData3;
  logic [3:0] cbAddr0, cbAddr1;
  logic [7:0] cbData0, cbData1;
  logic done;
  logic [3:0] bestMvX, bestMvY;
  logic [11:0] bestSad;

  logic [7:0] sw [256];
  logic [7:0] cb [16];
  logic [31:0] seed = 32'h1234_5678;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign swData0 = sw[swAddr0];
  assign swData1 = sw[swAddr1];
  assign swData2 = sw[swAddr2];
  assign swData3 = sw[swAddr3];
  assign cbData0 = cb[cbAddr0];
  assign cbData1 = cb[cbAddr1];

  qpel_refine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .hpX(hpX), .hpY(hpY),
    .swAddr0(swAddr0), .swAddr1(swAddr1), .swAddr2(swAddr2), .swAddr3(swAddr3),
    .swData0(swData0), .swData1(swData1), .swData2(swData2), .swData3(swData3),
    .cbAddr0(cbAddr0), .cbAddr1(cbAddr1), .cbData0(cbData0), .cbData1(cbData1),
    .done(done), .bestMvX(bestMvX), .bestMvY(bestMvY), .bestSad(bestSad)
  );

  function automatic int offX(input int k);
    int s;
    s = (k < 4) ? k : k + 1;
    return (s % 3) - 1;
  endfunction

  function automatic int offY(input int k);
    int s;
    s = (k < 4) ? k : k + 1;
    return (s / 3) - 1;
  endfunction

  function automatic int addrOf(input int hx, input int hy, input int n, input int dx, input int dy);
    return (6 + hy + 2 * (n / 4) + dy) * 16 + (6 + hx + 2 * (n % 4) + dx);
  endfunction

  function automatic int refSad(input int hx, input int hy, input int k);
    int acc, c, b, q, d;
    acc = 0;
    for (int n = 0; n < 16; n++) begin
      c = int'(sw[addrOf(hx, hy, n, 0, 0)]);
      b = int'(sw[addrOf(hx, hy, n, offX(k), offY(k))]);
      q = (c + b + 1) / 2;
      d = q - int'(cb[n]);
      acc += (d < 0) ? -d : d;
    end
    return acc;
  endfunction

  function automatic logic [7:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 256; i++) sw[i] = nextRand();
    for (int i = 0; i < 16; i++) cb[i] = nextRand();
  endtask

  // one search; checks R4 addressing, R6 timing and the result
  task automatic runSearch(input int hx, input int hy, input bit midStart,
                           input int expIdx, input int expSad, input string tag);
    bit cbOk, earlyDone;
    int badAddr;
    logic [3:0] expX, expY;
    expX = 4'(2 * hx + offX(expIdx));
    expY = 4'(2 * hy + offY(expIdx));
    cbOk = 1'b1; earlyDone = 1'b0; badAddr = 0;
    @(negedge clk);
    hpX = 2'(hx); hpY = 2'(hy); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int b = 0; b < 64; b++) begin
      if (cbAddr0 != 4'((b / 2) % 16) || cbAddr1 != 4'((b / 2) % 16)) begin
        cbOk = 1'b0; badAddr = int'(cbAddr0);
      end
      if (done) earlyDone = 1'b1;
      if (midStart && b == 20) begin
        start = 1'b1; hpX = 2'(-hx); hpY = 2'(-hy);
      end
      if (midStart && b == 22) start = 1'b0;
      @(posedge clk); #1;
    end
    if (done) earlyDone = 1'b1;
    check(cbOk, {"R4 current address schedule ", tag}, badAddr, -1);
    check(!earlyDone, {"R6 no early done ", tag}, int'(earlyDone), 0);
    @(posedge clk); #1;
    check(done == 1'b1, {"R6 done at edge 65 ", tag}, int'(done), 1);
    check(bestSad == 12'(expSad), {"R3 R5 sad ", tag}, int'(bestSad), expSad);
    check(bestMvX == expX && bestMvY == expY, {"R1 vector ", tag},
          int'({bestMvX, bestMvY}), int'({expX, expY}));
    @(posedge clk); #1;
    check(done == 1'b0, {"R6 done single cycle ", tag}, int'(done), 0);
  endtask

  function automatic void refBest(input int hx, input int hy, output int idx, output int s);
    int v;
    idx = 0; s = refSad(hx, hy, 0);
    for (int k = 1; k < 8; k++) begin
      v = refSad(hx, hy, k);
      if (v < s) begin s = v; idx = k; end
    end
  endfunction

  task automatic testReset();
    check(done == 1'b0 && bestSad == 12'd0 && bestMvX == 4'd0 && bestMvY == 4'd0,
          "R8 reset state", int'({done, bestSad}), 0);
  endtask

  task automatic testAllVectors();
    int idx, s;
    for (int hy = -1; hy <= 1; hy++) begin
      for (int hx = -1; hx <= 1; hx++) begin
        fillRandom();
        refBest(hx, hy, idx, s);
        runSearch(hx, hy, 1'b0, idx, s, "R2 random window");
      end
    end
  endtask

  task automatic testPlanted();
    fillRandom();
    for (int n = 0; n < 16; n++)
      cb[n] = 8'((int'(sw[addrOf(1, -1, n, 0, 0)]) + int'(sw[addrOf(1, -1, n, 0, 1)]) + 1) / 2);
    runSearch(1, -1, 1'b0, 6, 0, "R5 planted k6 minimum");
  endtask

  task automatic testTie();
    for (int i = 0; i < 256; i++) sw[i] = 8'd50;
    for (int i = 0; i < 16; i++) cb[i] = 8'd50;
    runSearch(0, 0, 1'b0, 0, 0, "R5 all equal lowest index");
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 256; i++) sw[i] = 8'd255;
    for (int i = 0; i < 16; i++) cb[i] = 8'd0;
    runSearch(-1, 1, 1'b0, 0, 4080, "R9 full-scale sad");
  endtask

  task automatic testBusyStart();
    int idx, s;
    fillRandom();
    refBest(1, 1, idx, s);
    runSearch(1, 1, 1'b1, idx, s, "R7 start during run ignored");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) sw[i] = 8'd0;
    for (int i = 0; i < 16; i++) cb[i] = 8'd0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testAllVectors();
    testPlanted();
    testTie();
    testSaturate();
    testBusyStart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule